// File: doc/BRIEF.md
# Fuse Configuration Store with Readback Lock

This block is the configuration memory of a small programmable logic device. It holds one flat space of fuse bits: the product-term array, whose first row drives the register clear term and whose last row drives the register set term. It also holds two mode bits for each output macrocell and a 64-bit user signature. The store drives the decoded configuration straight into the logic array, so a fuse that has been written is visible on the configuration outputs in the cycle after the write.

A programmer reaches the store through a one-command-per-cycle interface. The commands are: erase everything, write one bit at an address, read one bit at an address, and set the security lock. Reads and writes return a registered response one cycle after the command is taken. Once the lock is set, reads of any functional fuse (array or mode bits) return zero and flag the read as blocked, while the signature stays readable. The lock itself is cleared only by the multi-cycle erase, which also clears every fuse. During the erase the store reports busy and drops every command.

Top module: `fuse_map_store`

## Requirements
- R1: After the synchronous reset, busy, secured, every response output and every configuration output are 0.
- R2: Command codes on cmd_op are 0 none, 1 erase, 2 write, 3 read, 4 lock; other codes do nothing. An accepted write or read produces rsp_valid for exactly one cycle, in the cycle after the command edge. A read of a valid, readable address returns the last bit written there.
- R3: Array fuse n, for n from 0 to 3455, drives cfg_array[n]. Fuses 0 to 35 also appear on cfg_clr_row[0..35], and fuses 3420 to 3455 on cfg_set_row[0..35].
- R4: Macrocell m (0 to 9) takes its polarity bit from fuse 3456+2m (1 means active-high output) on cfg_pol_high[m], and its mode bit from fuse 3457+2m (1 means combinational, 0 registered) on cfg_comb[m].
- R5: Signature bit i (0 to 63) is fuse 3476+i. It can be written and read back like any other fuse.
- R6: After a lock command, a read of any address below 3476 returns rsp_data 0 with rsp_blocked 1.
- R7: With the lock set, signature reads return the stored bit with rsp_blocked 0.
- R8: A read or write at an address of 3540 or above returns rsp_err 1 and rsp_data 0 and changes no fuse.
- R9: An accepted erase clears every fuse, the signature and the lock at the command edge. busy is then high for exactly ERASE_CYCLES cycles.
- R10: While busy is high, every command is ignored: there is no response and no fuse or lock change.
- R11: Writes and reads never clear the lock; only an erase does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the blank state |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | 12 | Fuse address |
| cmd_wbit | input | 1 | Value for a write |
| busy | output | 1 | Erase in progress; commands dropped |
| secured | output | 1 | Readback lock is set |
| rsp_valid | output | 1 | Response to a read or write |
| rsp_data | output | 1 | Read bit |
| rsp_blocked | output | 1 | Read refused by the lock |
| rsp_err | output | 1 | Address out of range |
| cfg_array | output | 3456 | All product-term array fuses |
| cfg_clr_row | output | 36 | Register clear term row |
| cfg_set_row | output | 36 | Register set term row |
| cfg_pol_high | output | 10 | Per-macrocell active-high polarity |
| cfg_comb | output | 10 | Per-macrocell combinational mode |

## Verification
The hardest situation to reach is a command that arrives inside the erase window and would, if it were not dropped, leave a trace. Once the lock is set, the functional fuses can no longer be read, so that trace is only observable through the signature and the configuration outputs. The bench therefore fills the store with seeded random writes, sets the lock, and starts an erase. While busy is high it issues a signature write and a read, then checks that there was no response, and after the window it checks that the signature bit is still clear and that the lock is gone. Random reads before and after the lock sweep every address class against a bench model.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    // Default geometry of the fuse space
    localparam int FM_ROW_W     = 36;
    localparam int FM_N_ROWS    = 96;
    localparam int FM_N_MC      = 10;
    localparam int FM_SIG_BITS  = 64;
    localparam int FM_ERASE_CYC = 16;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_ERASE  = 3'd1,
        OP_WRITE  = 3'd2,
        OP_READ   = 3'd3,
        OP_LOCK   = 3'd4
    } fm_op_e;

    typedef enum logic [1:0] {
        CLS_ARRAY = 2'd0,
        CLS_MODE  = 2'd1,
        CLS_SIG   = 2'd2,
        CLS_BAD   = 2'd3
    } fm_cls_e;

    typedef struct packed {
        logic valid;
        logic data;
        logic blocked;
        logic err;
    } fm_rsp_t;

    // Functional fuses are the ones hidden by the lock
    function automatic logic is_functional(fm_cls_e c);
        return (c == CLS_ARRAY) || (c == CLS_MODE);
    endfunction

endpackage

// File: rtl/fuse_addr_dec.sv
module fuse_addr_dec
    import fuse_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int ARRAY_BITS = 3456,
    parameter int MODE_BASE  = 3456,
    parameter int SIG_BASE   = 3476,
    parameter int TOTAL      = 3540
) (
    input  logic [ADDR_W-1:0] addr,
    output fm_cls_e           cls,
    output logic [ADDR_W-1:0] off
);
    always_comb begin
        if (addr < ADDR_W'(ARRAY_BITS)) begin
            cls = CLS_ARRAY;
            off = addr;
        end else if (addr < ADDR_W'(SIG_BASE)) begin
            cls = CLS_MODE;
            off = addr - ADDR_W'(MODE_BASE);
        end else if (addr < ADDR_W'(TOTAL)) begin
            cls = CLS_SIG;
            off = addr - ADDR_W'(SIG_BASE);
        end else begin
            cls = CLS_BAD;
            off = '0;
        end
    end
endmodule

// File: rtl/fuse_erase_ctl.sv
module fuse_erase_ctl #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/fuse_mc_decode.sv
module fuse_mc_decode #(
    parameter int N_MC = 10
) (
    input  logic [2*N_MC-1:0] mode_bits,
    output logic [N_MC-1:0]   pol_high,
    output logic [N_MC-1:0]   comb
);
    for (genvar g = 0; g < N_MC; g++) begin : g_mc
        assign pol_high[g] = mode_bits[2*g];
        assign comb[g]     = mode_bits[2*g+1];
    end
endmodule

// File: rtl/fuse_map_store.sv
module fuse_map_store
    import fuse_pkg::*;
#(
    parameter int ROW_W        = FM_ROW_W,
    parameter int N_ROWS       = FM_N_ROWS,
    parameter int N_MC         = FM_N_MC,
    parameter int SIG_BITS     = FM_SIG_BITS,
    parameter int ERASE_CYCLES = FM_ERASE_CYC
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    input  logic [2:0]                  cmd_op,
    input  logic [$clog2(N_ROWS*ROW_W+2*N_MC+SIG_BITS+1)-1:0] cmd_addr,
    input  logic                        cmd_wbit,
    output logic                        busy,
    output logic                        secured,
    output logic                        rsp_valid,
    output logic                        rsp_data,
    output logic                        rsp_blocked,
    output logic                        rsp_err,
    output logic [N_ROWS*ROW_W-1:0]     cfg_array,
    output logic [ROW_W-1:0]            cfg_clr_row,
    output logic [ROW_W-1:0]            cfg_set_row,
    output logic [N_MC-1:0]             cfg_pol_high,
    output logic [N_MC-1:0]             cfg_comb
);
    localparam int ARRAY_BITS = N_ROWS * ROW_W;
    localparam int MODE_BITS  = 2 * N_MC;
    localparam int MODE_BASE  = ARRAY_BITS;
    localparam int SIG_BASE   = MODE_BASE + MODE_BITS;
    localparam int TOTAL      = SIG_BASE + SIG_BITS;
    localparam int ADDR_W     = $clog2(TOTAL + 1);
    localparam int MI_W       = $clog2(MODE_BITS);
    localparam int SI_W       = $clog2(SIG_BITS);

    logic [ARRAY_BITS-1:0] arr_q;
    logic [MODE_BITS-1:0]  mode_q;
    logic [SIG_BITS-1:0]   sig_q;
    logic                  lock_q;
    fm_rsp_t               rsp_q;

    fm_cls_e               cls;
    logic [ADDR_W-1:0]     off;
    logic                  take;
    logic                  erase_go;
    fm_op_e                op;

    fuse_addr_dec #(
        .ADDR_W     (ADDR_W),
        .ARRAY_BITS (ARRAY_BITS),
        .MODE_BASE  (MODE_BASE),
        .SIG_BASE   (SIG_BASE),
        .TOTAL      (TOTAL)
    ) u_dec (
        .addr (cmd_addr),
        .cls  (cls),
        .off  (off)
    );

    assign op       = fm_op_e'(cmd_op);
    assign take     = cmd_valid && !busy;
    assign erase_go = take && (op == OP_ERASE);

    fuse_erase_ctl #(
        .CYCLES (ERASE_CYCLES)
    ) u_erase (
        .clk   (clk),
        .rst   (rst),
        .start (erase_go),
        .busy  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q  <= '0;
            mode_q <= '0;
            sig_q  <= '0;
            lock_q <= 1'b0;
            rsp_q  <= '0;
        end else begin
            rsp_q <= '0;
            if (take) begin
                case (op)
                    OP_ERASE: begin
                        arr_q  <= '0;
                        mode_q <= '0;
                        sig_q  <= '0;
                        lock_q <= 1'b0;
                    end
                    OP_LOCK: begin
                        lock_q <= 1'b1;
                    end
                    OP_WRITE: begin
                        rsp_q.valid <= 1'b1;
                        case (cls)
                            CLS_ARRAY: arr_q[off]             <= cmd_wbit;
                            CLS_MODE:  mode_q[off[MI_W-1:0]]  <= cmd_wbit;
                            CLS_SIG:   sig_q[off[SI_W-1:0]]   <= cmd_wbit;
                            default:   rsp_q.err              <= 1'b1;
                        endcase
                    end
                    OP_READ: begin
                        rsp_q.valid <= 1'b1;
                        if (cls == CLS_BAD) begin
                            rsp_q.err <= 1'b1;
                        end else if (lock_q && is_functional(cls)) begin
                            rsp_q.blocked <= 1'b1;
                        end else begin
                            case (cls)
                                CLS_ARRAY: rsp_q.data <= arr_q[off];
                                CLS_MODE:  rsp_q.data <= mode_q[off[MI_W-1:0]];
                                default:   rsp_q.data <= sig_q[off[SI_W-1:0]];
                            endcase
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    fuse_mc_decode #(
        .N_MC (N_MC)
    ) u_mc (
        .mode_bits (mode_q),
        .pol_high  (cfg_pol_high),
        .comb      (cfg_comb)
    );

    assign secured     = lock_q;
    assign rsp_valid   = rsp_q.valid;
    assign rsp_data    = rsp_q.data;
    assign rsp_blocked = rsp_q.blocked;
    assign rsp_err     = rsp_q.err;
    assign cfg_array   = arr_q;
    assign cfg_clr_row = arr_q[ROW_W-1:0];
    assign cfg_set_row = arr_q[ARRAY_BITS-1 -: ROW_W];
endmodule

// File: rtl/fuse_map_store_chk.sv
module fuse_map_store_chk #(
    parameter int ERASE_CYCLES = 16,
    parameter int N_MC         = 10,
    parameter int ROW_W        = 36
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             busy,
    input logic             secured,
    input logic             rsp_valid,
    input logic             rsp_data,
    input logic             rsp_blocked,
    input logic             rsp_err,
    input logic [ROW_W-1:0] cfg_clr_row,
    input logic [ROW_W-1:0] cfg_set_row,
    input logic [N_MC-1:0]  cfg_pol_high,
    input logic [N_MC-1:0]  cfg_comb
);
    localparam int RUN_W = $clog2(ERASE_CYCLES + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !secured && !rsp_valid && cfg_clr_row == '0 && cfg_comb == '0));

    // R6
    blocked_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_blocked |-> (rsp_valid && !rsp_data && secured && !rsp_err));

    // R8
    bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && !rsp_data && !rsp_blocked));

    // R9
    erase_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == RUN_W'(ERASE_CYCLES)));

    // R9
    erase_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!secured && cfg_clr_row == '0 && cfg_set_row == '0
                         && cfg_pol_high == '0 && cfg_comb == '0));

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> !rsp_valid);

    // R11
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(secured) |-> busy);
endmodule

bind fuse_map_store fuse_map_store_chk #(
    .ERASE_CYCLES (ERASE_CYCLES),
    .N_MC         (N_MC),
    .ROW_W        (ROW_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .secured      (secured),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_blocked  (rsp_blocked),
    .rsp_err      (rsp_err),
    .cfg_clr_row  (cfg_clr_row),
    .cfg_set_row  (cfg_set_row),
    .cfg_pol_high (cfg_pol_high),
    .cfg_comb     (cfg_comb)
);

// File: tb/fuse_map_store_tb.sv
module fuse_map_store_tb;
    localparam int ERASE_CYC = 16;
    localparam int ARRAY_BITS = 3456;
    localparam int SIG_BASE = 3476;
    localparam int TOTAL = 3540;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [11:0] cmd_addr;
    logic        cmd_wbit;
    logic        busy, secured, rsp_valid, rsp_data, rsp_blocked, rsp_err;
    logic [ARRAY_BITS-1:0] cfg_array;
    logic [35:0] cfg_clr_row, cfg_set_row;
    logic [9:0]  cfg_pol_high, cfg_comb;

    int n_chk = 0;
    int n_fail = 0;
    bit [TOTAL-1:0] model;
    bit model_lock;

    fuse_map_store #(.ERASE_CYCLES(ERASE_CYC)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wbit(cmd_wbit), .busy(busy), .secured(secured),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_blocked(rsp_blocked),
        .rsp_err(rsp_err), .cfg_array(cfg_array), .cfg_clr_row(cfg_clr_row),
        .cfg_set_row(cfg_set_row), .cfg_pol_high(cfg_pol_high), .cfg_comb(cfg_comb)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input int addr, input logic wbit);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = 12'(addr);
        cmd_wbit  = wbit;
        @(posedge clk);
        #1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    // issue without waiting for the trailing negedge, result visible on return
    task automatic issue(input logic [2:0] op, input int addr, input logic wbit);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = 12'(addr);
        cmd_wbit  = wbit;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    function automatic bit exp_read(input int addr);
        if (addr >= TOTAL) return 1'b0;
        if (model_lock && addr < SIG_BASE) return 1'b0;
        return model[addr];
    endfunction

    task automatic chk_cfg(input string req);
        bit ok = 1'b1;
        ok &= (cfg_array == model[ARRAY_BITS-1:0]);
        ok &= (cfg_clr_row == model[35:0]);
        ok &= (cfg_set_row == model[3455:3420]);
        for (int k = 0; k < 10; k++) begin
            ok &= (cfg_pol_high[k] == model[3456 + 2*k]);
            ok &= (cfg_comb[k] == model[3457 + 2*k]);
        end
        chk(ok, req, {cfg_pol_high, cfg_comb}, 0);
    endtask

    task automatic wr(input int addr, input bit v);
        issue(3'd2, addr, v);
        chk(rsp_valid == 1'b1, "R2", rsp_valid, 1);
        if (addr < TOTAL) model[addr] = v;
    endtask

    task automatic rd_chk(input int addr, input string req);
        bit e;
        issue(3'd3, addr, 1'b0);
        e = exp_read(addr);
        chk(rsp_valid && rsp_data == e, req, {rsp_valid, rsp_data}, {1'b1, e});
        chk(rsp_blocked == (model_lock && addr < SIG_BASE), req, rsp_blocked,
            model_lock && addr < SIG_BASE);
        chk(rsp_err == (addr >= TOTAL), req, rsp_err, addr >= TOTAL);
    endtask

    initial begin
        int n;
        void'($urandom(32'd5150));
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_addr = '0; cmd_wbit = 1'b0;
        model = '0; model_lock = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk(!busy && !secured && !rsp_valid && !rsp_err && !rsp_blocked, "R1",
            {busy, secured, rsp_valid}, 0);
        chk_cfg("R1");

        // R3 / R4 directed map positions
        wr(5, 1'b1);
        chk(cfg_clr_row[5] == 1'b1 && cfg_array[5] == 1'b1, "R3", cfg_clr_row, 36'h20);
        wr(3420 + 7, 1'b1);
        chk(cfg_set_row[7] == 1'b1, "R3", cfg_set_row, 36'h80);
        wr(1000, 1'b1);
        chk(cfg_array[1000] == 1'b1, "R3", cfg_array[1000], 1);
        wr(3456 + 2*3, 1'b1);
        chk(cfg_pol_high == 10'h008 && cfg_comb == 10'h000, "R4", cfg_pol_high, 10'h008);
        wr(3457 + 2*9, 1'b1);
        chk(cfg_comb == 10'h200, "R4", cfg_comb, 10'h200);
        // R2 nop and undefined codes do nothing
        issue(3'd0, 5, 1'b0);
        chk(!rsp_valid && cfg_clr_row[5], "R2", rsp_valid, 0);
        issue(3'd7, 5, 1'b0);
        chk(!rsp_valid && cfg_clr_row[5] && !secured, "R2", rsp_valid, 0);

        // random fill then readback, all classes (R2, R5)
        for (int i = 0; i < 400; i++) begin
            int a = int'($urandom_range(TOTAL - 1, 0));
            wr(a, 1'($urandom()));
        end
        for (int i = 0; i < 32; i++) wr(SIG_BASE + 2*i, 1'b1);
        chk_cfg("R3");
        for (int i = 0; i < 200; i++) rd_chk(int'($urandom_range(TOTAL - 1, 0)), "R2");
        for (int i = 0; i < 64; i++) rd_chk(SIG_BASE + i, "R5");

        // R8 out-of-range
        issue(3'd2, 3540, 1'b1);
        chk(rsp_err && !rsp_data, "R8", rsp_err, 1);
        issue(3'd2, 4095, 1'b1);
        chk(rsp_err, "R8", rsp_err, 1);
        chk_cfg("R8");
        rd_chk(3540, "R8");
        rd_chk(4000, "R8");

        // lock (R6, R7, R11)
        do_cmd(3'd4, 0, 1'b0);
        model_lock = 1'b1;
        #1;
        chk(secured == 1'b1, "R6", secured, 1);
        for (int i = 0; i < 60; i++) rd_chk(int'($urandom_range(SIG_BASE - 1, 0)), "R6");
        rd_chk(5, "R6");
        rd_chk(3456 + 6, "R6");
        for (int i = 0; i < 64; i++) rd_chk(SIG_BASE + i, "R7");
        wr(SIG_BASE + 1, 1'b1);
        wr(200, 1'b1);
        rd_chk(200, "R11");
        chk(secured == 1'b1, "R11", secured, 1);

        // erase (R9, R10)
        issue(3'd1, 0, 1'b0);
        model = '0;
        model_lock = 1'b0;
        chk(busy && !secured, "R9", {busy, secured}, 2'b10);
        chk_cfg("R9");
        issue(3'd2, SIG_BASE + 3, 1'b1);
        chk(!rsp_valid, "R10", rsp_valid, 0);
        issue(3'd3, SIG_BASE + 3, 1'b0);
        chk(!rsp_valid, "R10", rsp_valid, 0);
        n = 2;
        while (busy && n < 1000) begin
            n++;
            issue(3'd4, 0, 1'b0);
        end
        chk(n == ERASE_CYC, "R9", n, ERASE_CYC);
        chk(!secured, "R10", secured, 0);
        rd_chk(SIG_BASE + 3, "R10");
        rd_chk(SIG_BASE + 1, "R9");
        rd_chk(200, "R9");
        rd_chk(5, "R9");
        chk_cfg("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule